// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block gathers thirteen level-sensitive interrupt lines, numbered 1 to 13, and presents the most urgent unmasked one to the processor. The processor sees a 3-bit interrupt level and an 8-bit vector. Each source owns an 8-bit control byte. Bits [4:0] of that byte form a combined level-and-priority code, and bits [4:2] of the same byte are the level the processor sees. Bit 7 selects autovectoring. A 16-bit mask register, in which a 1 blocks a source, sits beside a pending register. The pending register copies the lines every clock.

Software reaches every register through a byte-wide bus. A write lands on a clock edge, and a read returns the addressed byte combinationally. When autovectoring is off, three sources take their vectors from programmable registers: source 8 uses the watchdog vector, and sources 12 and 13 use the two serial-port vectors. Every other source falls back to 0x0F. A reset-status byte starts at 0x80 and is cleared one bit at a time by writing 1s to it.

The output side is a two-state machine. `ST_QUIET` drives level 0 and vector 0. `ST_ACTIVE` drives the registered level and vector of the current winner. There are three transitions. RAISE goes from `ST_QUIET` to `ST_ACTIVE` when a winner at level 1 or above appears. DROP goes from `ST_ACTIVE` to `ST_QUIET` when no such winner remains. HOLD stays in `ST_ACTIVE` and reloads level and vector every cycle.

Byte address map: 0x01–0x0D control byte of the source with that number; 0x10 mask[7:0]; 0x11 mask[15:8]; 0x12 pending[7:0]; 0x13 pending[15:8] (read only); 0x18 watchdog vector; 0x19 serial-port-A vector (source 12); 0x1A serial-port-B vector (source 13); 0x1C reset status. Unmapped reads return 0.

Top module: `irqc_top`

## Requirements
- R1: After reset the mask reads 0x3FFE. Control bytes 1..8 read 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C. Control bytes 9..11 read 0x80, and 12..13 read 0x00. All three vector registers read 0x0F, reset status reads 0x80, and cpu_level and cpu_vector are 0.
- R2: Pending bit n (bit n of the 16-bit value at 0x13:0x12) equals input line n as sampled on the previous rising edge. Bit 0 and bits 14–15 read 0.
- R3: A source whose mask bit (bit n of 0x11:0x10) is 1 never contributes to the outputs. With its mask bit 0 and its line high, it takes part in arbitration.
- R4: Among the active sources, the winner has the largest control[4:0]. On equal codes the lower-numbered source wins.
- R5: If the winning control[4:0] is below 4, or no source is active, cpu_level and cpu_vector are both 0.
- R6: cpu_level equals control[4:2] of the winner.
- R7: If control bit 7 of the winner is 1, cpu_vector is 24 + cpu_level.
- R8: If control bit 7 of the winner is 0, cpu_vector comes from a register that depends on the winner. Source 8 uses the byte at 0x18, source 12 the byte at 0x19, and source 13 the byte at 0x1A. Any other source gives 0x0F.
- R9: A write to 0x1C clears each reset-status bit whose written bit is 1 and leaves the other bits unchanged. No write sets a bit.
- R10: A register write on rising edge k shows on cpu_level and cpu_vector from rising edge k+1. A line change before edge k shows from edge k+1 (pending is updated on edge k).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for the byte bus |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_in | input | 13 | Interrupt lines, bit n is source n (index range 13:1) |
| cpu_level | output | 3 | Interrupt level presented to the processor |
| cpu_vector | output | 8 | Vector presented with the level |

## Verification
The checker assumes a clean reset and nothing more about irq_in: lines may change on any cycle, and each property reasons only about the cycle after a registered arbiter result. The pending-tracking and reset-status properties are gated on reset having been released for a full cycle. Because of that gate, line values held during reset never matter. The bench keeps irq_in at zero through reset, and it changes lines and bus signals only on falling edges. Every register update therefore lands on a single known rising edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_ACTIVE = 1'b1
    } irqc_state_e;

    // byte address map
    localparam int A_MASK_LO  = 'h10;
    localparam int A_MASK_HI  = 'h11;
    localparam int A_PEND_LO  = 'h12;
    localparam int A_PEND_HI  = 'h13;
    localparam int A_WDOG_VEC = 'h18;
    localparam int A_UA_VEC   = 'h19;
    localparam int A_UB_VEC   = 'h1A;
    localparam int A_RSTAT    = 'h1C;

    localparam logic [15:0] MASK_RST   = 16'h3FFE;
    localparam logic [7:0]  VEC_RST    = 8'h0F;
    localparam logic [7:0]  RSTAT_RST  = 8'h80;
    localparam logic [7:0]  FALLBACK_V = 8'h0F;
    localparam logic [7:0]  AUTO_BASE  = 8'd24;
    localparam logic [4:0]  MIN_CODE   = 5'd4;

    function automatic logic [7:0] ctrl_reset(input int idx);
        if (idx <= 7)  return 8'(idx * 4);
        if (idx == 8)  return 8'h1C;
        if (idx <= 11) return 8'h80;
        return 8'h00;
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    input  logic [NUM_SRC:1]               irq_in,
    output logic [NUM_SRC:1][DATA_W-1:0]   ctrl_q,
    output logic [2*DATA_W-1:0]            mask_q,
    output logic [2*DATA_W-1:0]            pend_q,
    output logic [DATA_W-1:0]              wdog_vec_q,
    output logic [DATA_W-1:0]              ua_vec_q,
    output logic [DATA_W-1:0]              ub_vec_q,
    output logic [DATA_W-1:0]              rstat_q
);
    localparam int MASK_W = 2 * DATA_W;

    logic [MASK_W-1:0] pend_d;

    always_comb begin
        pend_d              = '0;
        pend_d[NUM_SRC:1]   = irq_in;
    end

    // one control byte per source, address equal to source number
    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_ctrl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_q[g] <= DATA_W'(ctrl_reset(g));
            else if (we && addr == ADDR_W'(g))
                ctrl_q[g] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q     <= MASK_W'(MASK_RST);
            pend_q     <= '0;
            wdog_vec_q <= DATA_W'(VEC_RST);
            ua_vec_q   <= DATA_W'(VEC_RST);
            ub_vec_q   <= DATA_W'(VEC_RST);
            rstat_q    <= DATA_W'(RSTAT_RST);
        end else begin
            pend_q <= pend_d;
            if (we) begin
                if (addr == ADDR_W'(A_MASK_LO))  mask_q[DATA_W-1:0]      <= wdata;
                if (addr == ADDR_W'(A_MASK_HI))  mask_q[MASK_W-1:DATA_W] <= wdata;
                if (addr == ADDR_W'(A_WDOG_VEC)) wdog_vec_q <= wdata;
                if (addr == ADDR_W'(A_UA_VEC))   ua_vec_q   <= wdata;
                if (addr == ADDR_W'(A_UB_VEC))   ub_vec_q   <= wdata;
                if (addr == ADDR_W'(A_RSTAT))    rstat_q    <= rstat_q & ~wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 1; i <= NUM_SRC; i++)
            if (addr == ADDR_W'(i)) rdata = ctrl_q[i];
        if (addr == ADDR_W'(A_MASK_LO))  rdata = mask_q[DATA_W-1:0];
        if (addr == ADDR_W'(A_MASK_HI))  rdata = mask_q[MASK_W-1:DATA_W];
        if (addr == ADDR_W'(A_PEND_LO))  rdata = pend_q[DATA_W-1:0];
        if (addr == ADDR_W'(A_PEND_HI))  rdata = pend_q[MASK_W-1:DATA_W];
        if (addr == ADDR_W'(A_WDOG_VEC)) rdata = wdog_vec_q;
        if (addr == ADDR_W'(A_UA_VEC))   rdata = ua_vec_q;
        if (addr == ADDR_W'(A_UB_VEC))   rdata = ub_vec_q;
        if (addr == ADDR_W'(A_RSTAT))    rdata = rstat_q;
    end

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int DATA_W  = 8,
    localparam int SRC_W  = $clog2(NUM_SRC + 1)
) (
    input  logic [2*DATA_W-1:0]          pend,
    input  logic [2*DATA_W-1:0]          mask,
    input  logic [NUM_SRC:1][DATA_W-1:0] ctrl,
    output logic                         win_valid,
    output logic [SRC_W-1:0]             win_src,
    output logic [DATA_W-1:0]            win_ctrl
);
    logic [2*DATA_W-1:0] active;
    logic [4:0]          best;

    assign active = pend & ~mask;

    // strict greater-than keeps the lower-numbered source on a tie
    always_comb begin
        best     = '0;
        win_src  = '0;
        win_ctrl = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (active[i] && ctrl[i][4:0] > best) begin
                best     = ctrl[i][4:0];
                win_src  = SRC_W'(i);
                win_ctrl = ctrl[i];
            end
        end
        win_valid = (best >= MIN_CODE);
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC  = 13,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int WDOG_SRC = 8,
    parameter int UA_SRC   = 12,
    parameter int UB_SRC   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC:1]  irq_in,
    output logic [2:0]        cpu_level,
    output logic [DATA_W-1:0] cpu_vector
);
    localparam int SRC_W  = $clog2(NUM_SRC + 1);
    localparam int MASK_W = 2 * DATA_W;

    logic [NUM_SRC:1][DATA_W-1:0] ctrl_q;
    logic [MASK_W-1:0]            mask_q;
    logic [MASK_W-1:0]            pend_q;
    logic [DATA_W-1:0]            wdog_vec_q, ua_vec_q, ub_vec_q, rstat_q;
    logic                         win_valid;
    logic [SRC_W-1:0]             win_src;
    logic [DATA_W-1:0]            win_ctrl;
    logic [DATA_W-1:0]            vec_d, vec_q;
    logic [2:0]                   lvl_q;
    irqc_state_e                  state_q, state_d;

    irqc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .irq_in    (irq_in),
        .ctrl_q    (ctrl_q),
        .mask_q    (mask_q),
        .pend_q    (pend_q),
        .wdog_vec_q(wdog_vec_q),
        .ua_vec_q  (ua_vec_q),
        .ub_vec_q  (ub_vec_q),
        .rstat_q   (rstat_q)
    );

    irqc_arb #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_arb (
        .pend     (pend_q),
        .mask     (mask_q),
        .ctrl     (ctrl_q),
        .win_valid(win_valid),
        .win_src  (win_src),
        .win_ctrl (win_ctrl)
    );

    // vector selection for the current winner
    always_comb begin
        if (win_ctrl[7])
            vec_d = DATA_W'(AUTO_BASE) + DATA_W'(win_ctrl[4:2]);
        else if (win_src == SRC_W'(WDOG_SRC))
            vec_d = wdog_vec_q;
        else if (win_src == SRC_W'(UA_SRC))
            vec_d = ua_vec_q;
        else if (win_src == SRC_W'(UB_SRC))
            vec_d = ub_vec_q;
        else
            vec_d = DATA_W'(FALLBACK_V);
    end

    // RAISE / HOLD / DROP
    always_comb begin
        unique case (state_q)
            ST_QUIET:  state_d = win_valid ? ST_ACTIVE : ST_QUIET;
            ST_ACTIVE: state_d = win_valid ? ST_ACTIVE : ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            lvl_q   <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= win_ctrl[4:2];
            vec_q   <= vec_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_QUIET: begin
                cpu_level  = '0;
                cpu_vector = '0;
            end
            ST_ACTIVE: begin
                cpu_level  = lvl_q;
                cpu_vector = vec_q;
            end
            default: begin
                cpu_level  = '0;
                cpu_vector = '0;
            end
        endcase
    end

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int NUM_SRC = 13,
    parameter int DATA_W  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_SRC:1]    irq_in,
    input logic [2*DATA_W-1:0] pend_q,
    input logic [2*DATA_W-1:0] mask_q,
    input logic                win_valid,
    input logic [DATA_W-1:0]   win_ctrl,
    input logic [DATA_W-1:0]   rstat_q,
    input logic [2:0]          cpu_level,
    input logic [DATA_W-1:0]   cpu_vector
);

    AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pend_q[NUM_SRC:1] == $past(irq_in)); // R2

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~mask_q) == '0) |=> (cpu_level == 3'd0)); // R3

    AST_LOW_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |=> (cpu_level == 3'd0 && cpu_vector == '0)); // R5

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> (cpu_level == $past(win_ctrl[4:2]) && cpu_level != 3'd0)); // R6

    AST_AUTOVEC: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_ctrl[7]) |=> (cpu_vector == DATA_W'(24) + DATA_W'(cpu_level))); // R7

    AST_RSTAT_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((rstat_q & ~$past(rstat_q)) == '0)); // R9

endmodule

bind irqc_top irqc_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .win_valid (win_valid),
    .win_ctrl  (win_ctrl),
    .rstat_q   (rstat_q),
    .cpu_level (cpu_level),
    .cpu_vector(cpu_vector)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [13:1] irq_in = '0;
    logic [2:0]  cpu_level;
    logic [7:0]  cpu_vector;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  m_ctrl [1:13];
    logic [15:0] m_mask;
    logic [7:0]  m_wv, m_uav, m_ubv;

    always #5 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .cpu_level(cpu_level), .cpu_vector(cpu_vector)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_ctrl(input int s, input logic [7:0] v);
        wr(8'(s), v);
        m_ctrl[s] = v;
    endtask

    task automatic set_mask(input logic [15:0] m);
        wr(8'h10, m[7:0]);
        wr(8'h11, m[15:8]);
        m_mask = m;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    // expected outputs from the requirements
    function automatic logic [10:0] expect_out(input logic [13:1] lines);
        logic [4:0] best = '0;
        int         src = 0;
        logic [2:0] el;
        logic [7:0] ev;
        for (int i = 1; i <= 13; i++)
            if (lines[i] && !m_mask[i] && m_ctrl[i][4:0] > best) begin
                best = m_ctrl[i][4:0];
                src  = i;
            end
        if (best < 5'd4) return '0;
        el = m_ctrl[src][4:2];
        if (m_ctrl[src][7])  ev = 8'd24 + 8'(el);
        else if (src == 8)   ev = m_wv;
        else if (src == 12)  ev = m_uav;
        else if (src == 13)  ev = m_ubv;
        else                 ev = 8'h0F;
        return {el, ev};
    endfunction

    task automatic check_out(input string tag);
        logic [10:0] e = expect_out(irq_in);
        check({tag, " level"}, 16'(cpu_level), 16'(e[10:8]));
        check({tag, " vector"}, 16'(cpu_vector), 16'(e[7:0]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        for (int i = 1; i <= 13; i++)
            m_ctrl[i] = (i <= 7) ? 8'(i * 4) : (i == 8) ? 8'h1C : (i <= 11) ? 8'h80 : 8'h00;
        m_mask = 16'h3FFE; m_wv = 8'h0F; m_uav = 8'h0F; m_ubv = 8'h0F;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 level", 16'(cpu_level), 16'h0);
        check("R1 vector", 16'(cpu_vector), 16'h0);
        for (int i = 1; i <= 13; i++) begin
            rd(8'(i), d);
            check("R1 ctrl", 16'(d), 16'(m_ctrl[i]));
        end
        rd(8'h10, d); check("R1 mask lo", 16'(d), 16'hFE);
        rd(8'h11, d); check("R1 mask hi", 16'(d), 16'h3F);
        rd(8'h18, d); check("R1 wdog vec", 16'(d), 16'h0F);
        rd(8'h19, d); check("R1 ua vec", 16'(d), 16'h0F);
        rd(8'h1A, d); check("R1 ub vec", 16'(d), 16'h0F);
        rd(8'h1C, d); check("R1 rstat", 16'(d), 16'h80);

        // R2 pending tracks lines, walking ones and a few patterns
        for (int i = 1; i <= 13; i++) begin
            logic [7:0] lo, hi;
            @(negedge clk); irq_in = 13'(1) << (i - 1);
            @(negedge clk);
            rd(8'h12, lo); rd(8'h13, hi);
            check("R2 pending", {hi, lo}, 16'(1) << i);
        end
        @(negedge clk); irq_in = 13'h1FFF;
        settle();
        begin
            logic [7:0] lo, hi;
            rd(8'h12, lo); rd(8'h13, hi);
            check("R2 pending all", {hi, lo}, 16'h3FFE);
        end
        @(negedge clk); irq_in = '0;

        // R8 distinct programmable vectors
        wr(8'h18, 8'h40); m_wv = 8'h40;
        wr(8'h19, 8'h41); m_uav = 8'h41;
        wr(8'h1A, 8'h42); m_ubv = 8'h42;
        set_mask(16'h0000);

        // R5 R6 R7 R8 exhaustive single-source sweep
        for (int s = 1; s <= 13; s++) begin
            @(negedge clk); irq_in = 13'(1) << (s - 1);
            for (int c = 0; c < 64; c++) begin
                set_ctrl(s, {c[5], 2'b00, c[4:0]});
                settle();
                check_out("R5 R6 R7 R8 single");
            end
            set_ctrl(s, 8'h00);
        end

        // R4 explicit ties
        @(negedge clk); irq_in = '0; irq_in[9] = 1'b1; irq_in[12] = 1'b1;
        set_ctrl(9, 8'h14); set_ctrl(12, 8'h14);
        settle();
        check("R4 tie 9v12 vector", 16'(cpu_vector), 16'h0F);
        @(negedge clk); irq_in = '0; irq_in[8] = 1'b1; irq_in[13] = 1'b1;
        set_ctrl(8, 8'h14); set_ctrl(13, 8'h14);
        settle();
        check("R4 tie 8v13 vector", 16'(cpu_vector), 16'h40);
        set_ctrl(13, 8'h15);
        settle();
        check("R4 higher code wins", 16'(cpu_vector), 16'h42);

        // R3 mask blocks a lone source
        @(negedge clk); irq_in = '0; irq_in[5] = 1'b1;
        set_ctrl(5, 8'h9C);
        set_mask(16'h0020);
        settle();
        check("R3 masked level", 16'(cpu_level), 16'h0);
        set_mask(16'h0000);
        settle();
        check("R3 unmasked level", 16'(cpu_level), 16'h7);

        // R4 R3 random sweep over all sources
        for (int t = 0; t < 250; t++) begin
            for (int i = 1; i <= 13; i++) set_ctrl(i, 8'($urandom));
            set_mask(16'($urandom) & 16'h3FFE);
            @(negedge clk); irq_in = 13'($urandom);
            settle();
            check_out("R3 R4 random");
        end

        // R10 latency
        set_mask(16'h0000);
        for (int i = 1; i <= 13; i++) set_ctrl(i, 8'h00);
        @(negedge clk); irq_in = '0; irq_in[5] = 1'b1;
        set_ctrl(5, 8'h14);
        settle();
        check("R10 base level", 16'(cpu_level), 16'h5);
        set_ctrl(5, 8'h9C);
        check("R10 old level after write edge", 16'(cpu_level), 16'h5);
        @(negedge clk);
        check("R10 new level", 16'(cpu_level), 16'h7);
        check("R10 new vector", 16'(cpu_vector), 16'd31);
        irq_in = '0;
        @(negedge clk);
        check("R10 level one edge after drop", 16'(cpu_level), 16'h7);
        @(negedge clk);
        check("R10 level two edges after drop", 16'(cpu_level), 16'h0);
        check("R5 vector idle", 16'(cpu_vector), 16'h0);

        // R9 write-one-to-clear
        wr(8'h1C, 8'h00);
        rd(8'h1C, d); check("R9 zero write keeps", 16'(d), 16'h80);
        wr(8'h1C, 8'h7F);
        rd(8'h1C, d); check("R9 other bits keep", 16'(d), 16'h80);
        wr(8'h1C, 8'h80);
        rd(8'h1C, d); check("R9 clear", 16'(d), 16'h00);
        wr(8'h1C, 8'hFF);
        rd(8'h1C, d); check("R9 no set", 16'(d), 16'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule